// File: doc/BRIEF.md
# Microprogram Sequencer With Multiway Branch

This block steps a horizontally microcoded controller through its control store. It keeps a 9-bit microprogram counter and a 512-word store of 43-bit microinstructions, and on every clock edge it forms the next microaddress from fields of the word it is currently presenting. The next address is never produced by an incrementer or a separate dispatch table: the stored next-address field is used as it is, or some of its low bits are overwritten by a selected ALU condition bit (two-way branch) or by one nibble of the instruction register (sixteen-way opcode dispatch).

The controller around it loads the store through a plain write port, holds reset while doing so, and then lets the sequencer run from microaddress 0. A halt input freezes the counter, and with it the presented word, for as long as it is high. Executing the datapath fields of the word is left to the surrounding logic.

Top module: `useq_sequencer`

## Requirements
- R1: While reset (rst_n low) is held for at least two clocks with no store write, upc is 0 and uword shows the store word at address 0 at the moment reset is released.
- R2: uword always equals the store word at the address currently held in upc, both changing on the same clock edge.
- R3: Field layout of the 43-bit word (index 0 = LSB): next-address field in bits 30..38 with bit 30 its most significant bit and bit 38 its least; branch mode in bits 39..40 with bit 39 the more significant; test select in bits 27..28 with bit 27 the more significant.
- R4: Mode 0 (jump): the next upc equals the next-address field unchanged.
- R5: Mode 1 (two-way): the next upc takes the upper 8 bits of the next-address field and puts the selected condition bit in bit 0; bit 0 of the field has no effect.
- R6: Test select picks the condition bit: 0 = negative (cond_flags[3]), 1 = zero (cond_flags[2]), 2 = overflow (cond_flags[1]), 3 = carry (cond_flags[0]).
- R7: Mode 2 (high dispatch): the next upc keeps the upper 5 field bits and takes ir[7:4] as its low 4 bits.
- R8: Mode 3 (low dispatch): the next upc keeps the upper 5 field bits and takes ir[3:0] as its low 4 bits.
- R9: While halt is high at a clock edge, upc and uword keep their values; sequencing resumes from the held word once halt falls.
- R10: With wr_en high at a clock edge, wr_data is stored at wr_addr and is later presented on uword when upc reaches that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| halt | input | 1 | Freeze the microprogram counter |
| cond_flags | input | 4 | ALU condition bits {N, Z, V, C} |
| ir | input | 8 | Instruction register (opcode byte) |
| wr_en | input | 1 | Control store write enable |
| wr_addr | input | 9 | Control store write address |
| wr_data | input | 43 | Control store write data |
| upc | output | 9 | Current microprogram counter |
| uword | output | 43 | Microinstruction at upc |

## Verification
The properties on the branch modes assume cond_flags, ir and halt are steady across each rising edge, since each one compares the new upc with what those inputs and the old word held one cycle earlier. The check that a halted word stays put assumes no store write lands during the halt, and the reset property assumes the store at address 0 is not written in the final reset cycle. The stimulus changes every input only on falling edges, finishes all preloading with two quiet clocks before releasing reset, and never writes while the sequencer runs.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // Word field positions (lowest index of each field in the word vector)
  localparam int unsigned NA_LO   = 30;
  localparam int unsigned MODE_LO = 39;
  localparam int unsigned TEST_LO = 27;
  localparam int unsigned FLAG_W  = 4;

  typedef enum logic [1:0] {
    SEQ_JUMP  = 2'd0,
    SEQ_TEST  = 2'd1,
    SEQ_HINIB = 2'd2,
    SEQ_LONIB = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/useq_cstore.sv
module useq_cstore #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 43
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  // registered read: old data on a same-address collision
  always_ff @(posedge clk) begin
    rdata <= mem_q[raddr];
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned IR_W   = 8
) (
  input  logic [ADDR_W-1:0] fld_raw,   // word bits in ascending index order
  input  logic [1:0]        mode_raw,
  input  logic [1:0]        test_raw,
  input  logic [FLAG_W-1:0] cond_flags,
  input  logic [IR_W-1:0]   ir,
  input  logic              halt,
  input  logic [ADDR_W-1:0] upc,
  output logic [ADDR_W-1:0] fld,
  output seq_mode_e         mode,
  output logic              sel_flag,
  output logic [ADDR_W-1:0] nxt
);
  localparam int unsigned NIB  = IR_W / 2;
  localparam int unsigned KEEP = ADDR_W - NIB;

  // lowest word index carries the most significant address bit
  for (genvar i = 0; i < ADDR_W; i++) begin : g_rev
    assign fld[ADDR_W-1-i] = fld_raw[i];
  end

  logic [1:0] test_sel;
  assign mode     = seq_mode_e'({mode_raw[0], mode_raw[1]});
  assign test_sel = {test_raw[0], test_raw[1]};

  function automatic logic pick_flag(logic [FLAG_W-1:0] f, logic [1:0] s);
    return f[FLAG_W-1-int'(s)];
  endfunction

  function automatic logic [ADDR_W-1:0] form_next(
      seq_mode_e m, logic [ADDR_W-1:0] a, logic b, logic [IR_W-1:0] op);
    logic [ADDR_W-1:0] r;
    case (m)
      SEQ_JUMP:  r = a;
      SEQ_TEST:  r = {a[ADDR_W-1:1], b};
      SEQ_HINIB: r = {a[ADDR_W-1 -: KEEP], op[IR_W-1 -: NIB]};
      default:   r = {a[ADDR_W-1 -: KEEP], op[NIB-1:0]};
    endcase
    return r;
  endfunction

  assign sel_flag = pick_flag(cond_flags, test_sel);
  assign nxt      = halt ? upc : form_next(mode, fld, sel_flag, ir);
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned WORD_W = 43,
  parameter int unsigned IR_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic [3:0]        cond_flags,
  input  logic [IR_W-1:0]   ir,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [ADDR_W-1:0] upc,
  output logic [WORD_W-1:0] uword
);
  localparam int unsigned NIB = IR_W / 2;

  logic [ADDR_W-1:0] fld, nxt, rd_addr;
  seq_mode_e         mode;
  logic              sel_flag;

  useq_next #(.ADDR_W(ADDR_W), .IR_W(IR_W)) next_i (
    .fld_raw   (uword[NA_LO +: ADDR_W]),
    .mode_raw  (uword[MODE_LO +: 2]),
    .test_raw  (uword[TEST_LO +: 2]),
    .cond_flags(cond_flags),
    .ir        (ir),
    .halt      (halt),
    .upc       (upc),
    .fld       (fld),
    .mode      (mode),
    .sel_flag  (sel_flag),
    .nxt       (nxt)
  );

  // during reset the store keeps reading word 0 so it is ready at release
  assign rd_addr = rst_n ? nxt : '0;

  useq_cstore #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) store_i (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(wr_data),
    .raddr(rd_addr),
    .rdata(uword)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> upc == $past(upc));

  // R9
  halt_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !wr_en) |=> $stable(uword));

  // R4
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && mode == SEQ_JUMP) |=> upc == $past(fld));

  // R5
  twoway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && mode == SEQ_TEST) |=>
      (upc[0] == $past(sel_flag)) && (upc[ADDR_W-1:1] == $past(fld[ADDR_W-1:1])));

  // R7
  hinib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && mode == SEQ_HINIB) |=> upc[NIB-1:0] == $past(ir[IR_W-1 -: NIB]));

  // R8
  lonib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && mode == SEQ_LONIB) |=> upc[NIB-1:0] == $past(ir[NIB-1:0]));

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst_n)
    1'b1 |=> upc == '0);
endmodule

// File: tb/useq_sequencer_tb.sv
`timescale 1ns/100ps
module useq_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic [3:0]  cond_flags = 4'h0;
  logic [7:0]  ir = 8'h00;
  logic        wr_en = 1'b0;
  logic [8:0]  wr_addr = '0;
  logic [42:0] wr_data = '0;
  logic [8:0]  upc;
  logic [42:0] uword;

  int n_chk = 0;
  int n_bad = 0;
  logic [42:0] model [512];

  always #2.5 clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .halt(halt), .cond_flags(cond_flags), .ir(ir),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .upc(upc), .uword(uword)
  );

  // build a word per the R3 layout; low bits carry a tag
  function automatic logic [42:0] mk(int m, int t, int a);
    logic [42:0] w = '0;
    logic [8:0] av = a[8:0];
    for (int i = 0; i < 9; i++) w[30+i] = av[8-i];
    w[39] = m[1]; w[40] = m[0];
    w[27] = t[1]; w[28] = t[0];
    w[26:0] = 27'h5A0000 ^ {18'h0, av} ^ {25'h0, m[1:0]} ^ {21'h0, t[1:0], 4'h0};
    return w;
  endfunction

  task automatic chk(string req, logic [42:0] act, logic [42:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(int a, logic [42:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[8:0]; wr_data = w; model[a] = w;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0; halt = 1'b0; wr_en = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_jump();
    hold_reset();
    put(0, mk(0, 0, 9'h1A5));
    put(9'h1A5, mk(0, 2, 9'h003));
    put(3, mk(0, 1, 9'h000));
    release_reset();
    chk("R1 upc", 43'(upc), 43'd0);
    chk("R1 uword", uword, model[0]);
    step();
    chk("R4 R3 upc", 43'(upc), 43'h1A5);
    chk("R2 R10 uword", uword, model[9'h1A5]);
    step();
    chk("R4 upc", 43'(upc), 43'h003);
    chk("R2 uword", uword, model[3]);
    step();
    chk("R4 wrap upc", 43'(upc), 43'd0);
  endtask

  task automatic t_two_way();
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 2; v++) begin
        logic [3:0] one = 4'b1000 >> s;
        hold_reset();
        put(0, mk(1, s, 9'h0F1));
        put(9'h0F0, mk(0, 0, 0));
        put(9'h0F1, mk(0, 1, 0));
        cond_flags = (v == 1) ? one : ~one;
        release_reset();
        step();
        chk("R5 R6 upc", 43'(upc), 43'(9'h0F0 | 9'(v)));
        chk("R5 uword", uword, model[9'h0F0 | 9'(v)]);
      end
    end
  endtask

  task automatic t_dispatch();
    logic [7:0] ops [3] = '{8'h5D, 8'hA3, 8'h0F};
    for (int k = 0; k < 3; k++) begin
      hold_reset();
      put(0, mk(2, 3, 9'h1EF));
      put(9'h1E0 | 9'(ops[k][7:4]), mk(3, 0, 9'h02A));
      put(9'h020 | 9'(ops[k][3:0]), mk(0, 0, 0));
      ir = ops[k];
      release_reset();
      step();
      chk("R7 upc", 43'(upc), 43'(9'h1E0 | 9'(ops[k][7:4])));
      chk("R7 uword", uword, model[9'h1E0 | 9'(ops[k][7:4])]);
      step();
      chk("R8 upc", 43'(upc), 43'(9'h020 | 9'(ops[k][3:0])));
    end
  endtask

  task automatic t_halt();
    hold_reset();
    put(0, mk(0, 0, 9'h010));
    put(9'h010, mk(0, 0, 9'h020));
    put(9'h020, mk(0, 0, 9'h000));
    release_reset();
    step();
    chk("R9 pre upc", 43'(upc), 43'h010);
    halt = 1'b1;
    step();
    step();
    chk("R9 held upc", 43'(upc), 43'h010);
    chk("R9 held uword", uword, model[9'h010]);
    halt = 1'b0;
    step();
    chk("R9 resume upc", 43'(upc), 43'h020);
    chk("R9 resume uword", uword, model[9'h020]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_jump();
    t_two_way();
    t_dispatch();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule